// File: doc/BRIEF.md
# Pulsed Switch Contact Monitor

This block proves that a switch contact is really closed by watching it carry a test signal rather than a steady level. It drives a square wave of equal high and low times out toward the contact and samples whatever comes back. The returning signal is synchronised and then cleaned by a stability filter. Each clean rising edge sets a held "contact good" flag. A retriggerable timeout clears the flag as soon as clean transitions stop arriving.

Validity therefore depends on the return line toggling at the test rate. A wire shorted to a supply or to ground, or a contact that has welded or opened, holds a constant level. Such a fault is rejected within one timeout period, although a stuck-high level can raise the flag briefly first. Every delay is set in microseconds and turned into clock cycles from the clock-frequency parameter, so the block behaves the same at any clock rate.

Top module: `pulsed_switch_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, `contact_ok` and `test_pulse` are 0 after that edge; the filter, timer and flag state are cleared as well.
- R2: `test_pulse` is a square wave that holds each level for exactly HALF = CLK_FREQ_HZ*PULSE_HALF_US/1e6 cycles, starting low after reset.
- R3: A high excursion on `sense_in` that lasts fewer than FILT = CLK_FREQ_HZ*FILTER_US/1e6 cycles does not reach the flag, and `contact_ok` stays 0.
- R4: With `test_pulse` looped back to `sense_in`, `contact_ok` goes to 1 and stays 1 for as long as the loop is intact.
- R5: A constant high on `sense_in` may set `contact_ok` for about TIMEOUT cycles after the filtered rising edge, but clears it within FILT+TIMEOUT+a few synchroniser cycles.
- R6: If `sense_in` stops toggling and is held low, `contact_ok` falls within FILT+TIMEOUT+a few cycles, and it only ever falls through a timeout or a reset.
- R7: `contact_ok` rises only when the set pulse produced by a filtered rising edge is active. A `sense_in` held low never raises it.
- R8: Reset has priority over every other event. A timeout in the same cycle as an active set pulse clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | 1 | Raw return signal from the switch contact |
| test_pulse | output | 1 | Square-wave test signal driven toward the contact |
| contact_ok | output | 1 | Registered flag: contact carries the test signal |

## Verification
The hardest state to reach from the ports is a stuck-high fault. In that case the flag legitimately sets for a short while and must then be taken down by the timeout alone. The bench reaches it in two ways. In one, it breaks the loopback and drives a constant high from an idle low line, then checks the flag is up in the middle of that window and down after it. In the other, it freezes the line high while the loop is running. Sub-filter glitches are made by driving high excursions a few cycles shorter than the filter delay, repeated several times.

// File: rtl/psm_pkg.sv
package psm_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } filt_t;

    function automatic int unsigned us_to_cycles(longint unsigned freq_hz, int unsigned usec);
        longint unsigned c;
        c = (freq_hz * longint'(usec)) / 64'd1000000;
        return (c == 0) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/psm_pulse_gen.sv
module psm_pulse_gen #(
    parameter int unsigned HALF_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    output logic pulse_o
);
    localparam int unsigned CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            pulse_o <= ~pulse_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/psm_in_filter.sv
module psm_in_filter
    import psm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYC    = 40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw_i,
    output filt_t filt_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    logic [CW-1:0]          cnt_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_o <= '0;
        end else begin
            filt_o.rise <= 1'b0;
            filt_o.fall <= 1'b0;
            if (samp == filt_o.level) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q        <= '0;
                filt_o.level <= samp;
                filt_o.rise  <= samp;
                filt_o.fall  <= ~samp;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/psm_watch.sv
module psm_watch
    import psm_pkg::*;
#(
    parameter int unsigned SET_CYC     = 10,
    parameter int unsigned TIMEOUT_CYC = 75
) (
    input  logic  clk,
    input  logic  rst,
    input  filt_t filt_i,
    output logic  valid_o,
    output logic  set_act_o,
    output logic  expire_o
);
    localparam int unsigned SW = $clog2(SET_CYC + 1);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [SW-1:0] SET_LOAD = SW'(SET_CYC);
    localparam logic [TW-1:0] TMR_LOAD = TW'(TIMEOUT_CYC);
    localparam logic [TW-1:0] TMR_ONE  = TW'(1);

    logic [SW-1:0] set_cnt_q;
    logic [TW-1:0] tmr_q;
    tmr_state_e    tmr_st_q;

    assign set_act_o = (set_cnt_q != '0);
    assign expire_o  = (tmr_st_q == TMR_RUN) && (tmr_q == TMR_ONE)
                       && !filt_i.rise && !filt_i.fall;

    // stretched set pulse from each clean rising edge
    always_ff @(posedge clk) begin
        if (rst)              set_cnt_q <= '0;
        else if (filt_i.rise) set_cnt_q <= SET_LOAD;
        else if (set_act_o)   set_cnt_q <= set_cnt_q - 1'b1;
    end

    // rising edge arms, falling edge reloads, silence expires
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_st_q <= TMR_IDLE;
            tmr_q    <= '0;
        end else if (filt_i.rise) begin
            tmr_st_q <= TMR_RUN;
            tmr_q    <= TMR_LOAD;
        end else if (filt_i.fall && tmr_st_q == TMR_RUN) begin
            tmr_q <= TMR_LOAD;
        end else if (expire_o) begin
            tmr_st_q <= TMR_IDLE;
            tmr_q    <= '0;
        end else if (tmr_st_q == TMR_RUN) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    // held flag: reset, then expiry, then set
    always_ff @(posedge clk) begin
        if (rst)            valid_o <= 1'b0;
        else if (expire_o)  valid_o <= 1'b0;
        else if (set_act_o) valid_o <= 1'b1;
    end
endmodule

// File: rtl/pulsed_switch_monitor.sv
module pulsed_switch_monitor
    import psm_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ   = 125_000_000,
    parameter int unsigned     PULSE_HALF_US = 50,
    parameter int unsigned     FILTER_US     = 40,
    parameter int unsigned     SET_US        = 10,
    parameter int unsigned     TIMEOUT_US    = 75,
    parameter int unsigned     SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sense_in,
    output logic test_pulse,
    output logic contact_ok
);
    localparam int unsigned HALF_CYC    = us_to_cycles(CLK_FREQ_HZ, PULSE_HALF_US);
    localparam int unsigned FILT_CYC    = us_to_cycles(CLK_FREQ_HZ, FILTER_US);
    localparam int unsigned SET_CYC     = us_to_cycles(CLK_FREQ_HZ, SET_US);
    localparam int unsigned TIMEOUT_CYC = us_to_cycles(CLK_FREQ_HZ, TIMEOUT_US);

    filt_t filt_w;
    logic  set_act_w;
    logic  expire_w;

    psm_pulse_gen #(.HALF_CYC(HALF_CYC)) i_gen (
        .clk     (clk),
        .rst     (rst),
        .pulse_o (test_pulse)
    );

    psm_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) i_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (sense_in),
        .filt_o (filt_w)
    );

    psm_watch #(.SET_CYC(SET_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) i_watch (
        .clk       (clk),
        .rst       (rst),
        .filt_i    (filt_w),
        .valid_o   (contact_ok),
        .set_act_o (set_act_w),
        .expire_o  (expire_w)
    );
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
    parameter int unsigned HALF_CYC = 50
) (
    input logic clk,
    input logic rst,
    input logic test_pulse,
    input logic contact_ok,
    input logic set_act,
    input logic expire
);
    logic        last_q;
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            run_q  <= 0;
        end else begin
            last_q <= test_pulse;
            run_q  <= (test_pulse != last_q) ? 1 : run_q + 1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!contact_ok && !test_pulse));

    p_level_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (test_pulse != last_q) |-> (run_q == HALF_CYC));

    p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_q <= HALF_CYC);

    p_expire_wins_r8: assert property (@(posedge clk) disable iff (rst)
        expire |=> !contact_ok);

    p_rise_from_set_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(contact_ok) |-> $past(set_act));

    p_fall_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(contact_ok) |-> ($past(expire) || $past(rst)));
endmodule

bind pulsed_switch_monitor psm_checker #(.HALF_CYC(HALF_CYC)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .test_pulse (test_pulse),
    .contact_ok (contact_ok),
    .set_act    (set_act_w),
    .expire     (expire_w)
);

// File: tb/test_pulsed_switch_monitor.sv
module test_pulsed_switch_monitor;
    localparam int HALF = 50;
    localparam int FILT = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loop_en = 1'b0;
    logic force_lvl = 1'b0;
    logic sense_in;
    logic test_pulse;
    logic contact_ok;

    always #4 clk = ~clk;

    assign sense_in = loop_en ? test_pulse : force_lvl;

    pulsed_switch_monitor #(.CLK_FREQ_HZ(1_000_000)) i_pulsed_switch_monitor (
        .clk        (clk),
        .rst        (rst),
        .sense_in   (sense_in),
        .test_pulse (test_pulse),
        .contact_ok (contact_ok)
    );

    typedef struct {
        int unsigned at;
        int          exp;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          total = 0;
    int          bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_ok(int unsigned d, int e, string tag);
        exp_t it;
        it.at  = cyc + d;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop expected items as their cycle arrives
    always @(negedge clk) begin
        exp_t it;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it = sb.pop_front();
            check(it.tag, int'(contact_ok), it.exp);
        end
    end

    // R2 run-length monitor for the test output
    logic prev_p = 1'b0;
    int   run_len = 0;
    int   nruns = 0;
    always @(negedge clk) begin
        if (!rst && nruns <= 7) begin
            if (test_pulse !== prev_p) begin
                nruns++;
                if (nruns >= 2) check("R2 level hold length", run_len, HALF);
                run_len = 1;
                prev_p  = test_pulse;
            end else begin
                run_len++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired cycle=%0d", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(5);
        check("R1 flag after reset", int'(contact_ok), 0);
        check("R1 pulse after reset", int'(test_pulse), 0);
        rst = 1'b0;
        expect_ok(1, 0, "R1 flag held after release");

        // R7: line held low never raises the flag
        for (int k = 1; k <= 3; k++) expect_ok(k * 90, 0, "R7 held low");
        wait_n(300);

        // R3: excursions shorter than the filter
        for (int g = 0; g < 5; g++) begin
            force_lvl = 1'b1;
            wait_n(FILT - 5);
            force_lvl = 1'b0;
            expect_ok(2, 0, "R3 short glitch ignored");
            wait_n(40);
        end
        expect_ok(60, 0, "R3 after glitch burst");
        wait_n(100);

        // R4: healthy loop
        loop_en = 1'b1;
        wait_n(200);
        for (int i = 0; i < 27; i++) expect_ok(1 + i * 37, 1, "R4 loop intact");
        wait_n(1000);

        // R6: line stuck low
        loop_en   = 1'b0;
        force_lvl = 1'b0;
        expect_ok(2, 1, "R6 not instantaneous");
        expect_ok(140, 0, "R6 stuck low clears");
        wait_n(200);
        expect_ok(100, 0, "R6 stays clear");
        wait_n(150);

        // R5: stuck high from a running loop
        loop_en = 1'b1;
        wait_n(300);
        expect_ok(1, 1, "R4 relock");
        wait_n(3);
        force_lvl = 1'b1;
        loop_en   = 1'b0;
        expect_ok(2, 1, "R5 still set right after freeze");
        expect_ok(150, 0, "R5 frozen high clears");
        wait_n(400);
        expect_ok(1, 0, "R5 stays clear");
        wait_n(3);

        // R5: stuck high from an idle line sets briefly, then clears
        force_lvl = 1'b0;
        wait_n(300);
        force_lvl = 1'b1;
        expect_ok(60, 1, "R5 brief set");
        expect_ok(100, 1, "R5 brief set late");
        expect_ok(140, 0, "R5 timeout clears");
        wait_n(300);
        expect_ok(1, 0, "R5 remains clear");
        wait_n(3);

        // R8: reset beats a live loop
        loop_en = 1'b1;
        wait_n(300);
        expect_ok(1, 1, "R8 set before reset");
        wait_n(2);
        rst = 1'b1;
        wait_n(1);
        check("R8 reset clears flag", int'(contact_ok), 0);
        check("R1 reset clears pulse", int'(test_pulse), 0);
        rst = 1'b0;
        wait_n(300);
        expect_ok(1, 1, "R8 recovers after reset");
        wait_n(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule